// File: doc/BRIEF.md
# Wraparound Burst Address Counter

This block produces the word address for a four-beat burst into a synchronous cache memory. A burst opens when one of two active-low address strobes is sampled low while the device is selected. One strobe comes from the processor and one from the cache controller. On that edge the full start address is captured, and its two low bits become the burst start value. After that, each rising edge with the advance input low moves to the next beat. With the advance input high the burst is suspended and the current address is held.

The two low address bits are formed from the stored start value and a separate 2-bit beat count. The mode input picks one of two orders. In interleaved order the low bits are the start value XOR the beat count. In linear order they are the start value plus the beat count, modulo four. The upper address bits never change inside a burst.

Selection comes from two inputs: an active-low first chip enable and a pre-decoded active-high flag that stands for all the other enables. The processor strobe is honoured only while the first enable is low. When both strobes are low together, the processor strobe wins. A registered flag records which strobe opened the current burst, so that downstream write decode can tell a processor-opened burst from a controller-opened one.

Top module: `burst_addr_gen`

## Requirements
- R1: When a strobe is honoured on a rising edge, the next cycle shows `word_addr` equal to the `addr_in` sampled on that edge and `beat_idx` equal to 0.
- R2: When both strobes are low on a selected edge, the processor strobe is honoured and `open_by_proc` reads 1. A burst opened by the controller strobe alone shows `open_by_proc` = 0.
- R3: A strobe has no effect while the device is deselected (`ce1_n` = 1 or `ce_rest` = 0). In particular, the processor strobe is ignored whenever `ce1_n` = 1. In both cases `word_addr`, `beat_idx` and `open_by_proc` keep their values, apart from an advance.
- R4: With `order_ilv` = 1 (interleaved), `word_addr[1:0]` equals start XOR `beat_idx`. For example, start 10 gives 10, 11, 00, 01.
- R5: With `order_ilv` = 0 (linear), `word_addr[1:0]` equals (start + `beat_idx`) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: The beat count is 2 bits wide and wraps from 3 to 0. After four advances the address returns to the start address, and `word_addr[ADDR_W-1:2]` never changes without a strobe.
- R7: An edge with `adv_n` = 1 and no honoured strobe leaves `beat_idx` and `word_addr` unchanged (suspend).
- R8: An edge with `adv_n` = 0 and no honoured strobe increments `beat_idx` by one. A honoured strobe takes precedence over advance and restarts the count at 0.
- R9: A synchronous active-low reset clears `word_addr`, `beat_idx` and `open_by_proc` to zero, and strobes are ignored while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| ce_rest | input | 1 | Remaining chip enables, pre-decoded, 1 = active |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | Start address, captured when a strobe is honoured |
| word_addr | output | ADDR_W | Current word address of the burst |
| beat_idx | output | 2 | Beats advanced since the burst opened |
| open_by_proc | output | 1 | 1 if the processor strobe opened the current burst |

## Verification
A corrupted start value or beat count shows up on `word_addr[1:0]` in the very next cycle. The beat count also appears directly on `beat_idx`, so a mis-step can be told apart from a mis-captured start. A stray load or a missing load changes the upper address bits, or fails to change them, one cycle after the edge in question. The bench therefore compares all three outputs against an independent model after every single edge. Each burst is walked through all four beats in both orders, with several start values, so that a wrong wrap point or a swapped order appears within at most four cycles.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
// Assumes a four-beat burst, so the in-burst counter is two bits wide.
package burst_addr_pkg;
    localparam int unsigned BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bac_strobe_arb.sv
// Strobe qualification and priority.
// Decides whether a burst opens on this edge, and which strobe opened it.
// Assumes ce_rest already combines every enable except the first one.
module bac_strobe_arb (
    input  logic ce1_n,
    input  logic ce_rest,
    input  logic pstb_n,
    input  logic cstb_n,
    output logic take_load,
    output logic take_proc
);
    logic selected;
    logic proc_ok;
    logic ctrl_ok;

    // Qualify each strobe with chip selection; the processor strobe also needs ce1_n low.
    always_comb begin
        selected  = !ce1_n && ce_rest;
        proc_ok   = selected && !pstb_n;
        ctrl_ok   = selected && !cstb_n;
        take_proc = proc_ok;
        take_load = proc_ok || ctrl_ok;
    end

    // Check that an inactive first enable blocks any load.
    always_comb begin
        // R3
        proc_gate_chk: assert (!(ce1_n && take_load));
    end
endmodule

// File: rtl/bac_beat_ctr.sv
// Start-value and beat-count registers.
// Stores the captured start bits and the number of beats advanced so far.
// Assumes load has priority over step.
module bac_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  beat_t start_in,
    input  logic  step,
    output beat_t start_q,
    output beat_t beat_q
);
    // Capture the start bits on load and clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (load)
            start_q <= start_in;
    end

    // Restart the count on load, otherwise increment it on step; it wraps modulo four.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (load)
            beat_q <= '0;
        else if (step)
            beat_q <= beat_t'(beat_q + 1'b1);
    end

    // R8
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (beat_q == beat_t'($past(beat_q) + 1'b1)));

    // R7
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(beat_q) && $stable(start_q));

    // R1
    load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0) && (start_q == $past(start_in)));
endmodule

// File: rtl/bac_order_map.sv
// Low-bit order mapping.
// Combines the start value and the beat count into the low address bits.
// Interleaved order is a bitwise XOR; linear order is a modulo-four sum.
// Assumes the order input stays steady during a burst.
module bac_order_map
    import burst_addr_pkg::*;
(
    input  beat_t start,
    input  beat_t beat,
    input  logic  ilv,
    output beat_t lo
);
    beat_t xor_lo;
    beat_t sum_lo;

    // One XOR per bit for the interleaved order.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_lo[b] = start[b] ^ beat[b];
    end

    // Modulo-four sum for the linear order, then the mode select.
    always_comb begin
        sum_lo = beat_t'(start + beat);
        lo     = (order_e'(ilv) == ORD_INTERLEAVE) ? xor_lo : sum_lo;
    end

    // Check that the first beat always presents the start bits, whatever the order.
    always_comb begin
        // R4
        first_beat_chk: assert (!(beat == '0) || (lo == start));
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Wraparound burst address generator (top).
// Opens a four-beat burst on a qualified strobe and steps the low two address bits
// in interleaved or linear order on each advance. The upper bits stay fixed
// for the whole burst.
// Assumes chip enables other than the first arrive pre-decoded in ce_rest.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce_rest,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              open_by_proc
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    logic            take_load;
    logic            take_proc;
    beat_t           start_q;
    beat_t           beat_q;
    beat_t           lo_bits;
    logic [HI_W-1:0] hi_q;
    logic            src_q;

    bac_strobe_arb u_arb (
        .ce1_n     (ce1_n),
        .ce_rest   (ce_rest),
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .take_load (take_load),
        .take_proc (take_proc)
    );

    bac_beat_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_load),
        .start_in (addr_in[BEAT_W-1:0]),
        .step     (!adv_n),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    bac_order_map u_map (
        .start (start_q),
        .beat  (beat_q),
        .ilv   (order_ilv),
        .lo    (lo_bits)
    );

    // Hold the upper address bits and the opening strobe for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            src_q <= 1'b0;
        end else if (take_load) begin
            hi_q  <= addr_in[ADDR_W-1:BEAT_W];
            src_q <= take_proc;
        end
    end

    // Assemble the output address from the held upper bits and the mapped low bits.
    always_comb begin
        word_addr    = {hi_q, lo_bits};
        beat_idx     = beat_q;
        open_by_proc = src_q;
    end

    // R1
    open_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_load |=> (word_addr == $past(addr_in)) && (beat_idx == '0));

    // R2
    proc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !cstb_n && !ce1_n && ce_rest) |=> open_by_proc);

    // R3
    desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n || !ce_rest) |=> $stable(word_addr[ADDR_W-1:BEAT_W]) && $stable(open_by_proc));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

    // R7
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && !take_load) |=> $stable(beat_idx));
endmodule

// File: tb/tb_burst_addr_gen.sv
// Directed bench: one task per scenario, each checked against a model built from the requirements.
module tb_burst_addr_gen;
    localparam int unsigned AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce_rest = 1'b0;
    logic          pstb_n = 1'b1;
    logic          cstb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;
    logic [1:0]    beat_idx;
    logic          open_by_proc;

    int total = 0;
    int bad = 0;

    // Reference model state
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;
    logic          m_src = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce_rest(ce_rest),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .order_ilv(order_ilv),
        .addr_in(addr_in), .word_addr(word_addr), .beat_idx(beat_idx),
        .open_by_proc(open_by_proc)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_ilv ? (m_start ^ m_beat) : 2'(m_start + m_beat);
        return {m_hi, lo};
    endfunction

    task automatic check(input string tag);
        total++;
        if (word_addr !== exp_addr() || beat_idx !== m_beat || open_by_proc !== m_src) begin
            bad++;
            $display("FAIL %s: addr=%h beat=%0d src=%b expected addr=%h beat=%0d src=%b",
                     tag, word_addr, beat_idx, open_by_proc, exp_addr(), m_beat, m_src);
        end
    endtask

    // One edge: drive at negedge, update the model at the posedge, check at the next negedge.
    task automatic edge_step(input logic c1n, input logic cr, input logic pn, input logic cn,
                             input logic an, input logic [AW-1:0] a, input string tag);
        logic sel;
        @(negedge clk);
        ce1_n = c1n; ce_rest = cr; pstb_n = pn; cstb_n = cn; adv_n = an; addr_in = a;
        @(posedge clk);
        sel = !c1n && cr;
        if (!rst_n) begin
            m_hi = '0; m_start = '0; m_beat = '0; m_src = 1'b0;
        end else if (sel && (!pn || !cn)) begin
            m_hi = a[AW-1:2]; m_start = a[1:0]; m_beat = '0; m_src = !pn;
        end else if (!an) begin
            m_beat = 2'(m_beat + 1'b1);
        end
        @(negedge clk);
        check(tag);
        pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h1FFFF, "R9 strobe during reset");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 17'h0, "R9 reset state");
        rst_n = 1'b1;
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 17'h0, "R9 after release");
    endtask

    task automatic t_linear();
        order_ilv = 1'b0;
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h1ABC5, "R1 R5 open linear");
        for (int i = 0; i < 4; i++)
            edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R5 R6 linear step");
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h0F0F2, "R1 R5 open linear 10");
        for (int i = 0; i < 4; i++)
            edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R5 R6 linear step 10");
    endtask

    task automatic t_interleave();
        order_ilv = 1'b1;
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h12346, "R1 R4 open interleave");
        for (int i = 0; i < 4; i++)
            edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R4 R6 interleave step");
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 17'h05553, "R1 R4 open interleave 11");
        for (int i = 0; i < 5; i++)
            edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R4 R6 interleave step 11");
    endtask

    task automatic t_suspend();
        order_ilv = 1'b0;
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h00A01, "R1 open for suspend");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R8 advance");
        for (int i = 0; i < 3; i++)
            edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 17'h1FFFF, "R7 suspend hold");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R8 resume advance");
    endtask

    task automatic t_strobes();
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 17'h03332, "R2 controller only");
        edge_step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 17'h14441, "R2 both strobes");
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 17'h0AAA3, "R2 controller again");
    endtask

    task automatic t_deselect();
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h11110, "R1 open before deselect");
        edge_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 17'h1EEEF, "R3 proc strobe with ce1_n high");
        edge_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17'h1DDDE, "R3 both strobes with ce1_n high");
        edge_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 17'h1CCCD, "R3 ctrl strobe with ce_rest low");
        edge_step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 17'h1BBBC, "R3 gated strobe, advance taken");
    endtask

    task automatic t_restart();
        order_ilv = 1'b1;
        edge_step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 17'h08881, "R1 open for restart");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R8 step");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R8 step");
        edge_step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 17'h17772, "R8 strobe beats advance");
        edge_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h0, "R8 step after restart");
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_suspend();
        t_strobes();
        t_deselect();
        t_restart();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule